// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Peripheral

This block is a bus-attached multiplier that software drives with ordinary register writes. Software writes the first operand to one of four addresses. The address it picks sets the operation: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. Writing the second operand starts the arithmetic. The clock edge that takes that write also stores the new result, so a read in the very next cycle returns it.

Either operand can be loaded as a full word or as a byte, so word-by-word, word-by-byte, byte-by-word and byte-by-byte products all work. A byte is widened according to the signedness of the operation. The 32-bit result is read as a low word and a high word. A third word, the extension word, reports the sign of a signed result or the carry of an unsigned accumulation. The result and extension registers can also be written directly, which lets software preset the accumulator.

Top module: `mulacc_unit`

## Requirements
- R1: After reset every readable register returns 0x0000, and the operation is unsigned multiply (a second-operand write overwrites the result and leaves the extension word at 0).
- R2: The word addresses 0, 1, 2 and 3 all write the first operand. Address 0 selects unsigned multiply, 1 signed multiply, 2 unsigned accumulate and 3 signed accumulate. A read at any of these four addresses returns the first operand.
- R3: A write to address 4 loads the second operand and starts the operation. The low result word (address 5) and the high result word (address 6) show the new value on the next cycle. The read data port is combinational.
- R4: Unsigned multiply stores the 32-bit unsigned product and sets the extension word (address 7) to 0x0000.
- R5: Signed multiply stores the two's-complement product. The extension word becomes 0xFFFF when the product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the stored result. The extension word becomes 0x0001 on a carry out of bit 31 and 0x0000 otherwise.
- R7: Signed accumulate adds the signed product to the stored result, modulo 2^32. The extension word becomes 0xFFFF when the new result is negative and 0x0000 otherwise.
- R8: A byte write (bus_byte=1) takes bits 7:0 of the write data. For the first operand, the byte is sign-extended when the address written selects a signed operation and zero-extended otherwise. For the second operand, the currently selected operation decides the same way. The extended value is what reads back.
- R9: Addresses 5, 6 and 7 can be written to preset the accumulator. A byte write to them zero-extends.
- R10: A first-operand write leaves the result and extension words unchanged.
- R11: Both operands are retained, so each further second-operand write repeats the selected operation with the same first operand.
- R12: A write to an address above 7 changes nothing, and a read there returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_byte | input | 1 | 1 = byte write (bits 7:0), 0 = word write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, which gives a 32-bit result, and a 4-bit word address. The 4-bit address leaves eight unmapped addresses above the register set, so writes that must be ignored can be tested. At this width the carry out of bit 31 and the sign boundaries at 0x8000 and 0x80 can be hit with a few hand-computed operands, for example 0xFFFF times 0xFFFF, or a preset of 0xFFFFFFFF followed by an accumulate. Byte and word loads are mixed under both signed and unsigned operations, so each widening path is seen in its result.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

  // Operation code equals the low two bits of the operand-1 word address.
  typedef enum logic [1:0] {
    OP_MPYU = 2'd0,
    OP_MPYS = 2'd1,
    OP_MACU = 2'd2,
    OP_MACS = 2'd3
  } mac_op_e;

  localparam int unsigned NSLOT     = 8;
  localparam int unsigned SLOT_OP2  = 4;
  localparam int unsigned SLOT_RLO  = 5;
  localparam int unsigned SLOT_RHI  = 6;
  localparam int unsigned SLOT_EXT  = 7;

  function automatic logic op_signed(mac_op_e op);
    return op[0];
  endfunction

  function automatic logic op_accum(mac_op_e op);
    return op[1];
  endfunction

endpackage

// File: rtl/mulacc_decode.sv
module mulacc_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we,
  output logic [mulacc_pkg::NSLOT-1:0]   rd_hit,
  output logic [mulacc_pkg::NSLOT-1:0]   wr_hit
);
  localparam int unsigned NS = mulacc_pkg::NSLOT;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign rd_hit[g] = (addr == ADDR_W'(g));
    assign wr_hit[g] = rd_hit[g] & we;
  end

endmodule

// File: rtl/mulacc_opext.sv
module mulacc_opext #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              byte_en,
  input  logic              sign_en,
  output logic [DATA_W-1:0] wide
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic fill;

  always_comb begin
    fill = sign_en & raw[BYTE_W-1];
    if (byte_en) wide = {{(DATA_W-BYTE_W){fill}}, raw[BYTE_W-1:0]};
    else         wide = raw;
  end

endmodule

// File: rtl/mulacc_arith.sv
module mulacc_arith #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  input  mulacc_pkg::mac_op_e   op,
  input  logic [2*DATA_W-1:0]   acc_in,
  output logic [2*DATA_W-1:0]   res_out,
  output logic [DATA_W-1:0]     ext_out
);
  import mulacc_pkg::*;

  localparam int unsigned RES_W = 2 * DATA_W;

  logic             sgn;
  logic [RES_W-1:0] a_x;
  logic [RES_W-1:0] b_x;
  logic [RES_W-1:0] prod;
  logic [RES_W:0]   sum;

  always_comb begin
    sgn  = op_signed(op);
    // Widening to RES_W before the multiply makes the truncated product
    // correct for both two's-complement and unsigned operands.
    a_x  = {{DATA_W{sgn & op_a[DATA_W-1]}}, op_a};
    b_x  = {{DATA_W{sgn & op_b[DATA_W-1]}}, op_b};
    prod = a_x * b_x;
    sum  = {1'b0, acc_in} + {1'b0, prod};

    unique case (op)
      OP_MPYU: begin
        res_out = prod;
        ext_out = '0;
      end
      OP_MPYS: begin
        res_out = prod;
        ext_out = {DATA_W{prod[RES_W-1]}};
      end
      OP_MACU: begin
        res_out = sum[RES_W-1:0];
        ext_out = DATA_W'(sum[RES_W]);
      end
      default: begin
        res_out = sum[RES_W-1:0];
        ext_out = {DATA_W{sum[RES_W-1]}};
      end
    endcase
  end

endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_byte,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import mulacc_pkg::*;

  localparam int unsigned RES_W = 2 * DATA_W;

  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta;
  logic rst_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_live <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_live <= rst_meta;
    end
  end

  logic [NSLOT-1:0] rd_hit;
  logic [NSLOT-1:0] wr_hit;

  mulacc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  // state
  logic [DATA_W-1:0] op1_q, op1_d;
  logic [DATA_W-1:0] op2_q, op2_d;
  mac_op_e           mode_q, mode_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic [DATA_W-1:0] ext_q, ext_d;

  mac_op_e           new_op;
  logic              op1_wr;
  logic [DATA_W-1:0] op1_wval;
  logic [DATA_W-1:0] op2_wval;
  logic [DATA_W-1:0] plain_wval;
  logic [RES_W-1:0]  calc_res;
  logic [DATA_W-1:0] calc_ext;
  logic              upd_en;

  assign new_op = mac_op_e'(bus_addr[1:0]);
  assign op1_wr = |wr_hit[3:0];
  assign upd_en = bus_we;

  mulacc_opext #(.DATA_W(DATA_W)) u_ext_a (
    .raw     (bus_wdata),
    .byte_en (bus_byte),
    .sign_en (op_signed(new_op)),
    .wide    (op1_wval)
  );

  mulacc_opext #(.DATA_W(DATA_W)) u_ext_b (
    .raw     (bus_wdata),
    .byte_en (bus_byte),
    .sign_en (op_signed(mode_q)),
    .wide    (op2_wval)
  );

  mulacc_opext #(.DATA_W(DATA_W)) u_ext_r (
    .raw     (bus_wdata),
    .byte_en (bus_byte),
    .sign_en (1'b0),
    .wide    (plain_wval)
  );

  mulacc_arith #(.DATA_W(DATA_W)) u_arith (
    .op_a    (op1_q),
    .op_b    (op2_wval),
    .op      (mode_q),
    .acc_in  (res_q),
    .res_out (calc_res),
    .ext_out (calc_ext)
  );

  // next state
  always_comb begin
    op1_d  = op1_q;
    mode_d = mode_q;
    op2_d  = op2_q;
    res_d  = res_q;
    ext_d  = ext_q;
    if (op1_wr) begin
      op1_d  = op1_wval;
      mode_d = new_op;
    end
    if (wr_hit[SLOT_OP2]) begin
      op2_d = op2_wval;
      res_d = calc_res;
      ext_d = calc_ext;
    end
    if (wr_hit[SLOT_RLO]) res_d = {res_q[RES_W-1:DATA_W], plain_wval};
    if (wr_hit[SLOT_RHI]) res_d = {plain_wval, res_q[DATA_W-1:0]};
    if (wr_hit[SLOT_EXT]) ext_d = plain_wval;
  end

  // registers
  always_ff @(posedge clk or negedge rst_live) begin
    if (!rst_live) begin
      op1_q  <= '0;
      op2_q  <= '0;
      mode_q <= OP_MPYU;
      res_q  <= '0;
      ext_q  <= '0;
    end else if (upd_en) begin
      op1_q  <= op1_d;
      op2_q  <= op2_d;
      mode_q <= mode_d;
      res_q  <= res_d;
      ext_q  <= ext_d;
    end
  end

  // read path, no added latency
  always_comb begin
    bus_rdata = '0;
    if (|rd_hit[3:0])       bus_rdata = op1_q;
    if (rd_hit[SLOT_OP2])   bus_rdata = op2_q;
    if (rd_hit[SLOT_RLO])   bus_rdata = res_q[DATA_W-1:0];
    if (rd_hit[SLOT_RHI])   bus_rdata = res_q[RES_W-1:DATA_W];
    if (rd_hit[SLOT_EXT])   bus_rdata = ext_q;
  end

endmodule

// File: rtl/mulacc_chk.sv
module mulacc_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic                clk,
  input logic                rst_live,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic                bus_byte,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [1:0]          mode_q,
  input logic [DATA_W-1:0]   op1_q,
  input logic [2*DATA_W-1:0] res_q,
  input logic [DATA_W-1:0]   ext_q
);
  localparam int unsigned RES_W = 2 * DATA_W;

  logic             op1_wr;
  logic             op2_wr;
  logic             res_touch;
  logic [RES_W-1:0] a_z;
  logic [RES_W-1:0] b_z;

  assign op1_wr    = bus_we && (bus_addr < ADDR_W'(4));
  assign op2_wr    = bus_we && (bus_addr == ADDR_W'(4));
  assign res_touch = bus_we && (bus_addr >= ADDR_W'(4)) && (bus_addr <= ADDR_W'(7));
  assign a_z       = {{DATA_W{1'b0}}, op1_q};
  assign b_z       = {{DATA_W{1'b0}}, bus_wdata};

  assert_mode_select_R2: assert property (@(posedge clk) disable iff (!rst_live)
    op1_wr |=> (mode_q == $past(bus_addr[1:0])));

  assert_unsigned_product_R4: assert property (@(posedge clk) disable iff (!rst_live)
    (op2_wr && !bus_byte && mode_q == 2'd0) |=> (res_q == $past(a_z) * $past(b_z)) && (ext_q == '0));

  assert_signed_ext_R5: assert property (@(posedge clk) disable iff (!rst_live)
    (op2_wr && mode_q == 2'd1) |=> (ext_q == {DATA_W{res_q[RES_W-1]}}));

  assert_carry_only_R6: assert property (@(posedge clk) disable iff (!rst_live)
    (op2_wr && mode_q == 2'd2) |=> (ext_q[DATA_W-1:1] == '0));

  assert_acc_sign_R7: assert property (@(posedge clk) disable iff (!rst_live)
    (op2_wr && mode_q == 2'd3) |=> (ext_q == {DATA_W{res_q[RES_W-1]}}));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_live)
    !res_touch |=> ($stable(res_q) && $stable(ext_q)));

endmodule

bind mulacc_unit mulacc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_live  (rst_live),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_byte  (bus_byte),
  .bus_wdata (bus_wdata),
  .mode_q    (mode_q),
  .op1_q     (op1_q),
  .res_q     (res_q),
  .ext_q     (ext_q)
);

// File: tb/sim_mulacc_unit.sv
module sim_mulacc_unit;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic              bus_byte = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mulacc_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_byte  (bus_byte),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic wr(input int a, input logic [15:0] d, input logic b);
    @(negedge clk);
    bus_addr  = ADDR_W'(a);
    bus_wdata = d;
    bus_byte  = b;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_byte  = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [15:0] exp);
    bus_addr = ADDR_W'(a);
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic res_chk(input string tag, input logic [31:0] exp_r, input logic [15:0] exp_e);
    rd_chk(tag, 5, exp_r[15:0]);
    rd_chk(tag, 6, exp_r[31:16]);
    rd_chk(tag, 7, exp_e);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_chk("R1 reset value", a, 16'h0000);
    wr(5, 16'h0005, 1'b0);
    wr(4, 16'h0003, 1'b0);
    res_chk("R1 default unsigned multiply", 32'h0, 16'h0);
  endtask

  task automatic t_mode;
    wr(2, 16'hA5C3, 1'b0);
    for (int a = 0; a < 4; a++) rd_chk("R2 operand-1 readback", a, 16'hA5C3);
  endtask

  task automatic t_mpyu;
    wr(0, 16'hFFFF, 1'b0);
    wr(4, 16'hFFFF, 1'b0);
    res_chk("R3 R4 max unsigned", 32'hFFFE0001, 16'h0);
    rd_chk("R3 operand-2 readback", 4, 16'hFFFF);
    wr(0, 16'h1234, 1'b0);
    wr(4, 16'h5678, 1'b0);
    res_chk("R4 unsigned product", 32'h06260060, 16'h0);
  endtask

  task automatic t_mpys;
    wr(1, 16'hFFFD, 1'b0);
    wr(4, 16'h0007, 1'b0);
    res_chk("R5 negative product", 32'hFFFFFFEB, 16'hFFFF);
    wr(4, 16'hFFFF, 1'b0);
    res_chk("R5 R11 positive product, same operand 1", 32'h00000003, 16'h0);
  endtask

  task automatic t_macu;
    wr(5, 16'hFFFF, 1'b0);
    wr(6, 16'hFFFF, 1'b0);
    wr(2, 16'h0002, 1'b0);
    wr(4, 16'h0001, 1'b0);
    res_chk("R6 carry out of bit 31", 32'h00000001, 16'h0001);
    wr(4, 16'h0003, 1'b0);
    res_chk("R6 R11 accumulate no carry", 32'h00000007, 16'h0);
  endtask

  task automatic t_macs;
    wr(5, 16'h0000, 1'b0);
    wr(6, 16'h0000, 1'b0);
    wr(3, 16'h0005, 1'b0);
    wr(4, 16'hFFFE, 1'b0);
    res_chk("R7 accumulate to negative", 32'hFFFFFFF6, 16'hFFFF);
    wr(4, 16'h0004, 1'b0);
    res_chk("R7 accumulate back positive", 32'h0000000A, 16'h0);
  endtask

  task automatic t_bytes;
    wr(1, 16'h5580, 1'b1);
    rd_chk("R8 signed byte op1", 1, 16'hFF80);
    wr(4, 16'h7702, 1'b1);
    rd_chk("R8 signed byte op2", 4, 16'h0002);
    res_chk("R8 8x8 signed", 32'hFFFFFF00, 16'hFFFF);
    wr(0, 16'h5580, 1'b1);
    rd_chk("R8 unsigned byte op1", 0, 16'h0080);
    wr(4, 16'h11FF, 1'b1);
    rd_chk("R8 unsigned byte op2", 4, 16'h00FF);
    res_chk("R8 8x8 unsigned", 32'h00007F80, 16'h0);
    wr(1, 16'h0003, 1'b0);
    wr(4, 16'h00FF, 1'b1);
    rd_chk("R8 op2 widened by current mode", 4, 16'hFFFF);
    res_chk("R8 16x8 signed", 32'hFFFFFFFD, 16'hFFFF);
  endtask

  task automatic t_preset;
    wr(5, 16'h12AB, 1'b1);
    rd_chk("R9 byte preset low", 5, 16'h00AB);
    wr(6, 16'hBEEF, 1'b0);
    rd_chk("R9 preset high", 6, 16'hBEEF);
    wr(7, 16'h1234, 1'b0);
    rd_chk("R9 preset extension", 7, 16'h1234);
  endtask

  task automatic t_noeffect;
    wr(2, 16'h0F0F, 1'b0);
    res_chk("R10 op1 write leaves result", 32'hBEEF00AB, 16'h1234);
    wr(9, 16'hFFFF, 1'b0);
    wr(15, 16'hFFFF, 1'b0);
    rd_chk("R12 unmapped read", 9, 16'h0000);
    rd_chk("R12 op1 untouched", 0, 16'h0F0F);
    res_chk("R12 result untouched", 32'hBEEF00AB, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode();
    t_mpyu();
    t_mpys();
    t_macu();
    t_macs();
    t_bytes();
    t_preset();
    t_noeffect();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got hang expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule